// File: doc/BRIEF.md
# TDM Highway Receive Slot Deserializer

This block takes two serial receive highways that share one bit clock and one frame sync, and turns them into a stream of per-slot bytes for the line side. It runs on a fast system clock. It oversamples the highway clock, the frame sync and both data lines through a short synchronizer, and acts on one chosen edge of the highway clock. Configuration selects that edge. It also places slot 0 at a programmable byte offset and bit offset after frame sync, and chooses, slot by slot, which highway carries the data.

There are two slot formats. In the plain format each of the 32 slots is one 8-bit byte. In the paired format each slot is 16 bits: a data byte followed by a signaling byte, which makes 64 bytes per frame. When a slot completes, the block presents its slot index, data byte and signaling byte together with a one-cycle strobe. A slot that is switched off delivers a programmable idle byte in place of its data.

Top module: `tdm_rx_deser`

## Requirements
- R1: With `cfg_rise_i`=1 all highway inputs are taken at rising edges of `hw_clk_i`. With `cfg_rise_i`=0 they are taken at falling edges, and edges of the other direction have no effect.
- R2: The most significant bit of slot 0 is the bit taken `8*cfg_byte_off_i + cfg_bit_off_i` sampling edges after the sampling edge at which `hw_fs_i` was seen high. With both offsets 0, it is the bit taken at that same edge.
- R3: Each sampling edge that sees `hw_fs_i` high restarts the count of R2, even in the middle of a frame. Slots that were already complete are still delivered, and a slot that was only partly received is dropped.
- R4: A slot whose bit in `cfg_slot_en_i` is 0 delivers `cfg_idle_i` as its data byte.
- R5: A slot whose bit in `cfg_slot_en_i` is 0 delivers 8'hFF as its signaling byte.
- R6: With `cfg_pair_i`=0 a slot is 8 bits received MSB first and a frame holds 32 slots (256 bits). The signaling byte is always 8'hFF.
- R7: With `cfg_pair_i`=1 a slot is 16 bits: the data byte MSB first, then the signaling byte MSB first. A frame holds 32 slots (512 bits).
- R8: Slot n takes its bits from `hw_pri_i` when bit n of `cfg_slot_sel_i` is 0, and from `hw_sec_i` when it is 1.
- R9: No slot is delivered before the first frame sync after reset, for bits before the start of the window of R2, or for bits after the 32nd slot of a frame.
- R10: `slot_valid_o` is low in reset and is high for exactly one clock cycle per slot. It goes high on the third rising `clk` edge after the sampling edge of the slot's last bit, and `slot_idx_o` holds that slot's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the highway clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_clk_i | input | 1 | Highway bit clock |
| hw_fs_i | input | 1 | Highway frame sync, sampled like the data |
| hw_pri_i | input | 1 | Primary receive highway data |
| hw_sec_i | input | 1 | Secondary receive highway data |
| cfg_rise_i | input | 1 | 1: sample on rising edge, 0: on falling edge |
| cfg_bit_off_i | input | 3 | Bit offset of slot 0 |
| cfg_byte_off_i | input | 7 | Byte offset of slot 0 |
| cfg_pair_i | input | 1 | 1: 16-bit data plus signaling slots |
| cfg_slot_en_i | input | 32 | Per-slot enable |
| cfg_slot_sel_i | input | 32 | Per-slot highway select |
| cfg_idle_i | input | 8 | Idle byte for disabled slots |
| slot_valid_o | output | 1 | One-cycle strobe for a completed slot |
| slot_idx_o | output | 5 | Index of the completed slot |
| slot_data_o | output | 8 | Data byte of the slot |
| slot_sig_o | output | 8 | Signaling byte of the slot |

## Verification
A bit position counter that is off by even one edge rotates every delivered byte by one bit. It shows on the first strobe after frame sync and is exposed by random payload patterns. A counter that fails to restart on frame sync, or fails to stop at the end of the window, appears at the ports as missing or extra strobes, so the bench compares the number of strobes in each frame as well as their contents. Wrong enable or select indexing shows as idle bytes or other-highway bytes in the wrong slots of the same frame. A fault in the synchronizer or the edge select moves the strobe away from its fixed three-cycle distance from the edge, or shifts the sampled data by a half bit.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // One synchronizer stage carries all highway inputs together
  typedef struct packed {
    logic hclk;
    logic fs;
    logic pri;
    logic sec;
  } hw_bits_t;

  // Bit position, counted from frame sync, of the first bit of slot 0
  function automatic int win_start(input int byte_off, input int bit_off, input int bw);
    return byte_off * bw + bit_off;
  endfunction

  function automatic int slot_bits(input int bw, input logic pair);
    return pair ? 2 * bw : bw;
  endfunction

  function automatic int frame_bits(input int nslots, input int bw, input logic pair);
    return nslots * slot_bits(bw, pair);
  endfunction

  function automatic int slot_of(input int idx, input int bw, input logic pair);
    return pair ? idx / (2 * bw) : idx / bw;
  endfunction

  function automatic int bit_of(input int idx, input int bw, input logic pair);
    return pair ? idx % (2 * bw) : idx % bw;
  endfunction

endpackage

// File: rtl/tdm_rx_edge_sampler.sv
module tdm_rx_edge_sampler
  import tdm_rx_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hw_clk_i,
  input  logic     hw_fs_i,
  input  logic     hw_pri_i,
  input  logic     hw_sec_i,
  input  logic     rise_i,
  output logic     tick_o,
  output hw_bits_t bits_o
);

  hw_bits_t stage_q [SYNC];
  hw_bits_t in_w;
  logic     clk_prev_q;
  logic     clk_now;

  assign in_w = '{hclk: hw_clk_i, fs: hw_fs_i, pri: hw_pri_i, sec: hw_sec_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) stage_q[i] <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      stage_q[0] <= in_w;
      for (int i = 1; i < SYNC; i++) stage_q[i] <= stage_q[i-1];
      clk_prev_q <= stage_q[SYNC-1].hclk;
    end
  end

  assign clk_now = stage_q[SYNC-1].hclk;

  generate
    if (SYNC >= 1) begin : g_edge
      always_comb begin
        if (rise_i) tick_o = clk_now & ~clk_prev_q;
        else        tick_o = ~clk_now & clk_prev_q;
      end
    end
  endgenerate

  assign bits_o = stage_q[SYNC-1];

endmodule

// File: rtl/tdm_rx_slot_timer.sv
module tdm_rx_slot_timer
  import tdm_rx_pkg::*;
#(
  parameter int NSLOTS = 32,
  parameter int BYTE_W = 8,
  parameter int BOFF_W = 3,
  parameter int YOFF_W = 7,
  parameter int POS_W  = 11,
  localparam int SLOT_W = $clog2(NSLOTS),
  localparam int BIT_W  = $clog2(2 * BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              fs_i,
  input  logic [BOFF_W-1:0] bit_off_i,
  input  logic [YOFF_W-1:0] byte_off_i,
  input  logic              pair_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              in_win_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_n;
  logic [POS_W-1:0] start_w;
  logic [POS_W-1:0] len_w;
  logic [POS_W-1:0] idx_w;
  logic [BIT_W-1:0] bitn_w;

  // Position of the bit taken at this edge; saturates so no stray window appears
  always_comb begin
    if (fs_i)                 pos_n = '0;
    else if (pos_q == POS_MAX) pos_n = POS_MAX;
    else                      pos_n = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= POS_MAX;
    else if (tick_i) pos_q <= pos_n;
  end

  assign start_w  = POS_W'(win_start(int'(byte_off_i), int'(bit_off_i), BYTE_W));
  assign len_w    = POS_W'(frame_bits(NSLOTS, BYTE_W, pair_i));
  assign idx_w    = pos_n - start_w;
  assign in_win_o = (pos_n >= start_w) && (idx_w < len_w);
  assign slot_o   = SLOT_W'(slot_of(int'(idx_w), BYTE_W, pair_i));
  assign bitn_w   = BIT_W'(bit_of(int'(idx_w), BYTE_W, pair_i));
  assign last_o   = in_win_o && (bitn_w == BIT_W'(slot_bits(BYTE_W, pair_i) - 1));
  assign pos_o    = pos_q;

endmodule

// File: rtl/tdm_rx_slot_asm.sv
module tdm_rx_slot_asm #(
  parameter int NSLOTS = 32,
  parameter int BYTE_W = 8,
  localparam int SLOT_W = $clog2(NSLOTS),
  localparam int SH_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              in_win_i,
  input  logic              last_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              pri_i,
  input  logic              sec_i,
  input  logic              pair_i,
  input  logic [NSLOTS-1:0] slot_en_i,
  input  logic [NSLOTS-1:0] slot_sel_i,
  input  logic [BYTE_W-1:0] idle_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] idx_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] sig_o
);

  logic [SH_W-1:0]   shreg_q;
  logic [SH_W-1:0]   shreg_n;
  logic              pick_w;
  logic              en_w;
  logic [BYTE_W-1:0] data_n;
  logic [BYTE_W-1:0] sig_n;

  assign pick_w  = slot_sel_i[slot_i] ? sec_i : pri_i;
  assign shreg_n = {shreg_q[SH_W-2:0], pick_w};
  assign en_w    = slot_en_i[slot_i];

  always_comb begin
    if (!en_w)       data_n = idle_i;
    else if (pair_i) data_n = shreg_n[SH_W-1 -: BYTE_W];
    else             data_n = shreg_n[BYTE_W-1:0];
    if (pair_i && en_w) sig_n = shreg_n[BYTE_W-1:0];
    else                sig_n = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else if (tick_i && in_win_i) shreg_q <= shreg_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      data_o  <= '0;
      sig_o   <= '0;
    end else begin
      valid_o <= tick_i && last_i;
      if (tick_i && last_i) begin
        idx_o  <= slot_i;
        data_o <= data_n;
        sig_o  <= sig_n;
      end
    end
  end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
#(
  parameter int NSLOTS = 32,
  parameter int BYTE_W = 8,
  parameter int BOFF_W = 3,
  parameter int YOFF_W = 7,
  parameter int SYNC   = 2,
  localparam int SLOT_W    = $clog2(NSLOTS),
  localparam int START_MAX = ((1 << YOFF_W) - 1) * BYTE_W + (1 << BOFF_W) - 1,
  localparam int LEN_MAX   = NSLOTS * 2 * BYTE_W,
  localparam int POS_W     = $clog2(START_MAX + LEN_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_clk_i,
  input  logic              hw_fs_i,
  input  logic              hw_pri_i,
  input  logic              hw_sec_i,
  input  logic              cfg_rise_i,
  input  logic [BOFF_W-1:0] cfg_bit_off_i,
  input  logic [YOFF_W-1:0] cfg_byte_off_i,
  input  logic              cfg_pair_i,
  input  logic [NSLOTS-1:0] cfg_slot_en_i,
  input  logic [NSLOTS-1:0] cfg_slot_sel_i,
  input  logic [BYTE_W-1:0] cfg_idle_i,
  output logic              slot_valid_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [BYTE_W-1:0] slot_data_o,
  output logic [BYTE_W-1:0] slot_sig_o
);

  // Named internal events for the checker
  logic              bit_tick;
  hw_bits_t          bits_w;
  logic              fs_bit;
  logic [POS_W-1:0]  timer_pos;
  logic              win_bit;
  logic [SLOT_W-1:0] cur_slot;
  logic              last_bit;
  logic              slot_done;
  logic [SLOT_W-1:0] done_slot;

  tdm_rx_edge_sampler #(.SYNC(SYNC)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_clk_i (hw_clk_i),
    .hw_fs_i  (hw_fs_i),
    .hw_pri_i (hw_pri_i),
    .hw_sec_i (hw_sec_i),
    .rise_i   (cfg_rise_i),
    .tick_o   (bit_tick),
    .bits_o   (bits_w)
  );

  assign fs_bit = bits_w.fs;

  tdm_rx_slot_timer #(
    .NSLOTS(NSLOTS), .BYTE_W(BYTE_W), .BOFF_W(BOFF_W),
    .YOFF_W(YOFF_W), .POS_W(POS_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (bit_tick),
    .fs_i       (fs_bit),
    .bit_off_i  (cfg_bit_off_i),
    .byte_off_i (cfg_byte_off_i),
    .pair_i     (cfg_pair_i),
    .pos_o      (timer_pos),
    .in_win_o   (win_bit),
    .slot_o     (cur_slot),
    .last_o     (last_bit)
  );

  assign slot_done = bit_tick && last_bit;
  assign done_slot = cur_slot;

  tdm_rx_slot_asm #(.NSLOTS(NSLOTS), .BYTE_W(BYTE_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (bit_tick),
    .in_win_i   (win_bit),
    .last_i     (last_bit),
    .slot_i     (cur_slot),
    .pri_i      (bits_w.pri),
    .sec_i      (bits_w.sec),
    .pair_i     (cfg_pair_i),
    .slot_en_i  (cfg_slot_en_i),
    .slot_sel_i (cfg_slot_sel_i),
    .idle_i     (cfg_idle_i),
    .valid_o    (slot_valid_o),
    .idx_o      (slot_idx_o),
    .data_o     (slot_data_o),
    .sig_o      (slot_sig_o)
  );

endmodule

// File: rtl/tdm_rx_deser_chk.sv
module tdm_rx_deser_chk #(
  parameter int NSLOTS = 32,
  parameter int BYTE_W = 8,
  parameter int POS_W  = 11,
  localparam int SLOT_W = $clog2(NSLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              fs_bit,
  input logic [POS_W-1:0]  timer_pos,
  input logic              slot_done,
  input logic [SLOT_W-1:0] done_slot,
  input logic [NSLOTS-1:0] cfg_slot_en_i,
  input logic [BYTE_W-1:0] cfg_idle_i,
  input logic              cfg_pair_i,
  input logic              slot_valid_o,
  input logic [SLOT_W-1:0] slot_idx_o,
  input logic [BYTE_W-1:0] slot_data_o,
  input logic [BYTE_W-1:0] slot_sig_o
);

  a_r3_fs_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && fs_bit |=> timer_pos == '0);

  a_r4_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done && !cfg_slot_en_i[done_slot] |=> slot_data_o == $past(cfg_idle_i));

  a_r5_idle_sig: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done && !cfg_slot_en_i[done_slot] |=> slot_sig_o == '1);

  a_r6_plain_sig: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done && !cfg_pair_i |=> slot_sig_o == '1);

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid_o |=> !slot_valid_o);

  a_r10_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid_o |-> $past(bit_tick));

  a_r10_index: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |=> slot_valid_o && slot_idx_o == $past(done_slot));

endmodule

bind tdm_rx_deser tdm_rx_deser_chk #(
  .NSLOTS(NSLOTS), .BYTE_W(BYTE_W), .POS_W(POS_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .fs_bit        (fs_bit),
  .timer_pos     (timer_pos),
  .slot_done     (slot_done),
  .done_slot     (done_slot),
  .cfg_slot_en_i (cfg_slot_en_i),
  .cfg_idle_i    (cfg_idle_i),
  .cfg_pair_i    (cfg_pair_i),
  .slot_valid_o  (slot_valid_o),
  .slot_idx_o    (slot_idx_o),
  .slot_data_o   (slot_data_o),
  .slot_sig_o    (slot_sig_o)
);

// File: tb/tdm_rx_deser_tb.sv
`timescale 1ns/1ps
module tdm_rx_deser_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_clk = 1'b0;
  logic        hw_fs = 1'b0;
  logic        hw_pri = 1'b0;
  logic        hw_sec = 1'b0;
  logic        cfg_rise = 1'b1;
  logic [2:0]  cfg_bit_off = '0;
  logic [6:0]  cfg_byte_off = '0;
  logic        cfg_pair = 1'b0;
  logic [31:0] cfg_en = '1;
  logic [31:0] cfg_sel = '0;
  logic [7:0]  cfg_idle = 8'h55;
  logic        slot_valid_o;
  logic [4:0]  slot_idx_o;
  logic [7:0]  slot_data_o;
  logic [7:0]  slot_sig_o;

  int checks = 0;
  int errors = 0;
  int mp = -1;
  logic [15:0] macc = '0;
  logic [20:0] exp_q [256];
  logic [20:0] got_q [256];
  int n_exp = 0;
  int n_got = 0;
  realtime t_edge = 0;
  logic prev_v = 1'b0;

  always #2.5 clk = ~clk;

  tdm_rx_deser u_dut (
    .clk (clk), .rst_n (rst_n),
    .hw_clk_i (hw_clk), .hw_fs_i (hw_fs), .hw_pri_i (hw_pri), .hw_sec_i (hw_sec),
    .cfg_rise_i (cfg_rise), .cfg_bit_off_i (cfg_bit_off), .cfg_byte_off_i (cfg_byte_off),
    .cfg_pair_i (cfg_pair), .cfg_slot_en_i (cfg_en), .cfg_slot_sel_i (cfg_sel),
    .cfg_idle_i (cfg_idle),
    .slot_valid_o (slot_valid_o), .slot_idx_o (slot_idx_o),
    .slot_data_o (slot_data_o), .slot_sig_o (slot_sig_o)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    summary();
  end

  // Strobe monitor: R10 latency and width
  always @(negedge clk) begin
    if (rst_n && slot_valid_o) begin
      checks++;
      if ($realtime - t_edge != 15.0) begin
        errors++;
        $display("FAIL R10 strobe delay got %0t exp 15ns", $realtime - t_edge);
      end
      if (prev_v) begin
        errors++;
        $display("FAIL R10 strobe width got 2+ cycles exp 1");
      end
      if (n_got < 256) got_q[n_got] = {slot_idx_o, slot_data_o, slot_sig_o};
      n_got++;
    end
    prev_v = slot_valid_o;
  end

  function automatic int win_len();
    return cfg_pair ? 512 : 256;
  endfunction

  function automatic int first_bit();
    return int'(cfg_byte_off) * 8 + int'(cfg_bit_off);
  endfunction

  // Drive one bit period; the bench model predicts the slots from the requirements
  task automatic drive_bit(input logic fs, input logic a, input logic b);
    int sb, k, s, bp;
    logic bv;
    hw_clk = ~cfg_rise;
    hw_fs  = fs;
    hw_pri = a;
    hw_sec = b;
    if (fs) mp = 0;
    else if (mp >= 0) mp++;
    if (mp >= 0) begin
      sb = cfg_pair ? 16 : 8;
      k  = mp - first_bit();
      if (k >= 0 && k < win_len()) begin
        s  = k / sb;
        bp = k % sb;
        bv = cfg_sel[s] ? b : a;
        macc = (bp == 0) ? {15'd0, bv} : {macc[14:0], bv};
        if (bp == sb - 1) begin
          exp_q[n_exp] = {5'(s),
                          cfg_en[s] ? (cfg_pair ? macc[15:8] : macc[7:0]) : cfg_idle,
                          (cfg_pair && cfg_en[s]) ? macc[7:0] : 8'hFF};
          n_exp++;
        end
      end
    end
    #20;
    hw_clk = cfg_rise;
    t_edge = $realtime;
    #20;
  endtask

  task automatic run_frame(input int lead, input int tail, input int cut);
    int total;
    for (int i = 0; i < lead; i++) drive_bit(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    total = (cut > 0) ? cut : first_bit() + win_len() + tail;
    for (int i = 0; i < total; i++)
      drive_bit(i == 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
  endtask

  task automatic compare(input string tag);
    repeat (10) @(negedge clk);
    checks++;
    if (n_got != n_exp) begin
      errors++;
      $display("FAIL %s slot count got %0d exp %0d", tag, n_got, n_exp);
    end
    for (int i = 0; i < n_exp && i < n_got && i < 256; i++) begin
      checks++;
      if (got_q[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s entry %0d {idx,data,sig} got %h exp %h", tag, i, got_q[i], exp_q[i]);
      end
    end
    n_got = 0;
    n_exp = 0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: quiet outputs after reset
    checks++;
    if (slot_valid_o !== 1'b0 || slot_data_o !== 8'h00 || slot_sig_o !== 8'h00) begin
      errors++;
      $display("FAIL R10 reset state got v=%b d=%h s=%h exp 0 00 00",
               slot_valid_o, slot_data_o, slot_sig_o);
    end

    // R9: no frame sync yet, nothing delivered
    for (int i = 0; i < 40; i++) drive_bit(1'b0, 1'b1, 1'b1);
    compare("R9 no-sync");

    // R2 R6: zero offsets, plain slots, all enabled, primary only
    cfg_rise = 1'b1; cfg_byte_off = 7'd0; cfg_bit_off = 3'd0; cfg_pair = 1'b0;
    cfg_en = '1; cfg_sel = '0;
    run_frame(0, 5, 0);
    compare("R2 R6 plain zero-offset");

    // R1 R8: falling-edge sampling, alternate highway per slot
    cfg_rise = 1'b0; cfg_byte_off = 7'd3; cfg_bit_off = 3'd5; cfg_sel = 32'hAAAA_AAAA;
    run_frame(0, 3, 0);
    compare("R1 R8 falling edge");

    // R7 R2 R4 R5: paired slots at largest offsets
    cfg_rise = 1'b1; cfg_pair = 1'b1; cfg_byte_off = 7'd127; cfg_bit_off = 3'd7;
    cfg_en = $urandom; cfg_sel = $urandom; cfg_idle = 8'hC3;
    run_frame(0, 4, 0);
    compare("R7 R2 R4 R5 max offset");

    // R4 R5: every slot disabled
    cfg_pair = 1'b0; cfg_byte_off = 7'd1; cfg_bit_off = 3'd2; cfg_en = '0; cfg_idle = 8'h3C;
    run_frame(0, 2, 0);
    compare("R4 R5 all disabled");

    // R3: sync arrives mid-frame
    cfg_en = '1; cfg_sel = $urandom; cfg_byte_off = 7'd0; cfg_bit_off = 3'd0;
    run_frame(0, 0, 100);
    run_frame(0, 6, 0);
    compare("R3 realign");

    // R9: stray bits before sync and after window
    run_frame(6, 9, 0);
    compare("R9 lead and tail");

    // R8 R4 R7 R1: random configurations
    for (int f = 0; f < 8; f++) begin
      cfg_rise     = 1'($urandom_range(0, 1));
      cfg_pair     = 1'($urandom_range(0, 1));
      cfg_byte_off = 7'($urandom_range(0, 40));
      cfg_bit_off  = 3'($urandom_range(0, 7));
      cfg_en       = $urandom;
      cfg_sel      = $urandom;
      cfg_idle     = 8'($urandom);
      run_frame(0, $urandom_range(0, 12), 0);
      compare("R8 R4 R7 R1 random");
    end

    summary();
  end

endmodule